// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block sits between the OR sums of a programmable logic array and the device pins. Each cell takes one OR sum and one per-pin enable term and turns them into a pin drive value, a pin drive enable and a feedback bit that returns to the array. Two configuration bits per cell pick the output type and the output polarity. The type is either a registered output from a D flip-flop or a combinatorial output taken straight from the sum. The polarity is either active-high or active-low.

All cells share one clock, one synchronous preset term and one asynchronous clear term. The preset term forces every register high at the next rising clock edge. The clear term forces every register low at once, with no clock edge needed, and it wins over the preset. The pin is not modelled as a tristate wire. It appears as three plain signals: a drive value, a drive enable and the value read back from the pin. The power-up reset is asynchronous and active-low. It is released to the registers through a synchronizer.

Top module: `mcell_bank`

## Requirements
- R1: While `rst_n` is low, every register holds 0. With every cell set to registered active-high (code 2'b11), `fb_o` and `pin_out_o` are all zero.
- R2: With configuration bit 0 set (registered), a cell's register takes the value of `sum_i` at each rising clock edge. The new value shows on `fb_o` after that edge.
- R3: With configuration bit 0 clear (combinatorial), `pin_out_o` follows `sum_i` in the same cycle, with no clock edge in between, after the polarity is applied.
- R4: When `preset_i` is high at a rising clock edge and `clear_i` is low, every register becomes 1, whatever `sum_i` holds.
- R5: When `clear_i` is high, every register goes to 0 at once, with no clock edge needed. It stays 0 at any edge where `preset_i` is also high.
- R6: With configuration bit 1 set, `pin_out_o` equals the selected value (register or sum). With bit 1 clear, `pin_out_o` is the inverse of the selected value.
- R7: `pin_oe_o` of each cell is high exactly when that cell's `oe_term_i` bit is high. An enable term that is always true keeps the pin driven.
- R8: In registered mode, `fb_o` is the register output before polarity is applied. In combinatorial mode, `fb_o` equals `pin_in_i`.
- R9: Each cell uses its own 2-bit field `cfg_i[2*i+1:2*i]`, so cells with different modes work side by side. Preset and clear act on all cells in the same cycle.
- R10: After `rst_n` rises, the registers stay at 0 through the first two rising edges. The third edge is the first one at which they load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all registers |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sum_i | input | N_CELLS | OR sum for each cell |
| oe_term_i | input | N_CELLS | Output enable term for each cell |
| preset_i | input | 1 | Global synchronous preset term |
| clear_i | input | 1 | Global asynchronous clear term |
| cfg_i | input | 2*N_CELLS | Per cell: bit 0 selects registered mode, bit 1 selects active-high |
| pin_in_i | input | N_CELLS | Value read back from each pin |
| pin_out_o | output | N_CELLS | Drive value for each pin |
| pin_oe_o | output | N_CELLS | Drive enable for each pin |
| fb_o | output | N_CELLS | Feedback into the array |

## Verification
Combinatorial results (the combinatorial pin value, the polarity, the drive enable and the combinatorial feedback) are due in the same cycle as the input change. The bench samples them 1 ns after it drives the inputs, before any clock edge. Registered results are due one rising edge after the sample. The bench updates its own register model at the edge and compares 1 ns later. The clear is checked 1 ns after it is raised in the middle of a cycle, with no edge between the raise and the check. After reset release the bench expects no load at the first two edges and a load at the third.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int unsigned CFG_W = 2;

  // bit 1: active-high polarity, bit 0: registered output
  typedef struct packed {
    logic act_high;
    logic registered;
  } mcell_cfg_t;

  function automatic logic apply_pol(input logic val, input logic act_high);
    return act_high ? val : ~val;
  endfunction
endpackage

// File: rtl/mcell_rst_sync.sv
module mcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mcell_dff.sv
module mcell_dff (
  input  logic clk,
  input  logic aclr_n,
  input  logic preset_i,
  input  logic d_i,
  output logic q_o
);
  logic q_d;

  // the synchronous preset takes the place of the data input
  always_comb begin
    q_d = preset_i ? 1'b1 : d_i;
  end

  // clear and reset share the asynchronous path, so clear beats preset
  always_ff @(posedge clk or negedge aclr_n) begin
    if (!aclr_n) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/mcell_outsel.sv
module mcell_outsel
  import mcell_pkg::*;
(
  input  mcell_cfg_t cfg_i,
  input  logic       sum_i,
  input  logic       q_i,
  input  logic       pin_in_i,
  output logic       pin_out_o,
  output logic       fb_o
);
  logic sel;

  always_comb begin
    sel       = cfg_i.registered ? q_i : sum_i;
    pin_out_o = apply_pol(sel, cfg_i.act_high);
    fb_o      = cfg_i.registered ? q_i : pin_in_i;
  end
endmodule

// File: rtl/mcell_slice.sv
module mcell_slice
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       aclr_n,
  input  logic       preset_i,
  input  mcell_cfg_t cfg_i,
  input  logic       sum_i,
  input  logic       oe_term_i,
  input  logic       pin_in_i,
  output logic       pin_out_o,
  output logic       pin_oe_o,
  output logic       fb_o
);
  logic q;

  mcell_dff u_dff (
    .clk      (clk),
    .aclr_n   (aclr_n),
    .preset_i (preset_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  mcell_outsel u_sel (
    .cfg_i     (cfg_i),
    .sum_i     (sum_i),
    .q_i       (q),
    .pin_in_i  (pin_in_i),
    .pin_out_o (pin_out_o),
    .fb_o      (fb_o)
  );

  assign pin_oe_o = oe_term_i;
endmodule

// File: rtl/mcell_bank.sv
module mcell_bank
  import mcell_pkg::*;
#(
  parameter int unsigned N_CELLS    = 10,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CELLS-1:0]       sum_i,
  input  logic [N_CELLS-1:0]       oe_term_i,
  input  logic                     preset_i,
  input  logic                     clear_i,
  input  logic [CFG_W*N_CELLS-1:0] cfg_i,
  input  logic [N_CELLS-1:0]       pin_in_i,
  output logic [N_CELLS-1:0]       pin_out_o,
  output logic [N_CELLS-1:0]       pin_oe_o,
  output logic [N_CELLS-1:0]       fb_o
);
  logic rst_sync_n;
  logic aclr_n;

  mcell_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // global clear term joins the released reset on the asynchronous path
  assign aclr_n = rst_sync_n & ~clear_i;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    mcell_cfg_t cell_cfg;
    assign cell_cfg = mcell_cfg_t'(cfg_i[CFG_W*i +: CFG_W]);

    mcell_slice u_slice (
      .clk       (clk),
      .aclr_n    (aclr_n),
      .preset_i  (preset_i),
      .cfg_i     (cell_cfg),
      .sum_i     (sum_i[i]),
      .oe_term_i (oe_term_i[i]),
      .pin_in_i  (pin_in_i[i]),
      .pin_out_o (pin_out_o[i]),
      .pin_oe_o  (pin_oe_o[i]),
      .fb_o      (fb_o[i])
    );
  end
endmodule

// File: rtl/mcell_bank_chk.sv
module mcell_bank_chk #(
  parameter int unsigned N_CELLS = 10
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 preset_i,
  input logic                 clear_i,
  input logic [N_CELLS-1:0]   sum_i,
  input logic [2*N_CELLS-1:0] cfg_i,
  input logic [N_CELLS-1:0]   pin_in_i,
  input logic [N_CELLS-1:0]   pin_out_o,
  input logic [N_CELLS-1:0]   fb_o
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_i[2*i] && !preset_i && !clear_i) |=>
      (clear_i || !cfg_i[2*i] || fb_o[i] == $past(sum_i[i])));

    assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_i[2*i] && preset_i && !clear_i) |=>
      (clear_i || !cfg_i[2*i] || fb_o[i]));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_i[2*i] && clear_i) |-> !fb_o[i]);

    assert_comb_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !cfg_i[2*i] |-> (pin_out_o[i] == (cfg_i[2*i+1] ? sum_i[i] : ~sum_i[i])));

    assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cfg_i[2*i] |-> (pin_out_o[i] == (cfg_i[2*i+1] ? fb_o[i] : ~fb_o[i])));

    assert_feedback_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !cfg_i[2*i] |-> (fb_o[i] == pin_in_i[i]));
  end
endmodule

bind mcell_bank mcell_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .preset_i   (preset_i),
  .clear_i    (clear_i),
  .sum_i      (sum_i),
  .cfg_i      (cfg_i),
  .pin_in_i   (pin_in_i),
  .pin_out_o  (pin_out_o),
  .fb_o       (fb_o)
);

// File: tb/sim_mcell_bank.sv
`timescale 1ns/1ps
module sim_mcell_bank;
  localparam int N = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic [N-1:0]   sum, oe, pin_in;
  logic           preset, clear;
  logic [2*N-1:0] cfg;
  logic [N-1:0]   pin_out, pin_oe, fb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [N-1:0] exp_q;

  mcell_bank #(.N_CELLS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sum_i(sum), .oe_term_i(oe),
    .preset_i(preset), .clear_i(clear), .cfg_i(cfg), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .fb_o(fb)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic s;
      s    = cfg[2*i] ? exp_q[i] : sum[i];
      r[i] = cfg[2*i+1] ? s : ~s;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_fb();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = cfg[2*i] ? exp_q[i] : pin_in[i];
    return r;
  endfunction

  function automatic logic [2*N-1:0] mode_all(input logic [1:0] m);
    return {N{m}};
  endfunction

  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < N; i++) exp_q[i] = clear ? 1'b0 : (preset ? 1'b1 : sum[i]);
    #1;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R6 pin_out"}, pin_out, exp_out());
    chk({tag, " R8 fb"}, fb, exp_fb());
    chk({tag, " R7 oe"}, pin_oe, oe);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sum = '0; oe = '0; pin_in = '0;
    preset = 1'b0; clear = 1'b0; cfg = mode_all(2'b11); exp_q = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 fb in reset", fb, '0);
    chk("R1 pin_out in reset", pin_out, '0);

    // R10: reset release through the synchronizer
    @(negedge clk);
    rst_n = 1'b1; preset = 1'b1; sum = '1;
    @(posedge clk); #1;
    chk("R10 edge 1 no load", fb, '0);
    @(posedge clk); #1;
    chk("R10 edge 2 no load", fb, '0);
    @(posedge clk); #1;
    chk("R10 edge 3 loads", fb, '1);
    exp_q = '1;
    preset = 1'b0;

    // sweep of all four modes on all cells
    for (int m = 0; m < 4; m++) begin
      cfg = mode_all(2'(m));
      for (int p = 0; p < 16; p++) begin
        sum    = N'((p * 37 + m * 11) * 13);
        pin_in = ~sum ^ N'(p * 3);
        oe     = N'(p * 5 + m * 97);
        #1;
        chk("R3 comb same cycle", pin_out, exp_out());
        check_all("sweep pre-edge");
        tick();
        chk("R2 registered capture", fb, exp_fb());
        check_all("sweep post-edge");
      end
    end

    // R9: mixed modes with occasional preset
    for (int i = 0; i < N; i++) cfg[2*i +: 2] = 2'(i);
    for (int p = 0; p < 24; p++) begin
      sum    = N'(p * 211 + 5);
      pin_in = N'(p * 77);
      oe     = N'(p * 19);
      preset = (p % 5 == 0);
      #1;
      check_all("R9 mixed pre-edge");
      tick();
      check_all("R9 mixed post-edge");
    end
    preset = 1'b0;

    // R4: preset overrides the sum
    cfg = mode_all(2'b11); sum = '0; preset = 1'b1;
    tick();
    chk("R4 preset sets all", fb, '1);
    preset = 1'b0;

    // R5: clear mid-cycle, then clear with preset
    clear = 1'b1; exp_q = '0;
    #1;
    chk("R5 clear without edge", fb, '0);
    chk("R5 clear active-high pin", pin_out, '0);
    preset = 1'b1; sum = '1;
    tick();
    chk("R5 clear beats preset", fb, '0);
    clear = 1'b0; preset = 1'b0; sum = N'(10'h2a5);
    tick();
    chk("R2 capture after clear", fb, N'(10'h2a5));

    // R6 active-low registered
    cfg = mode_all(2'b01);
    #1;
    chk("R6 active-low registered", pin_out, ~N'(10'h2a5));

    // R7 always-true enable term
    oe = '1;
    #1;
    chk("R7 always enabled", pin_oe, '1);
    oe = '0;
    #1;
    chk("R7 disabled", pin_oe, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule